// File: doc/BRIEF.md
# Four-Unit I/O Window Decoder with Shared Interrupt

This block sits between a host I/O bus and a card that carries four identical parallel-interface units. Each unit has three data ports and one command register. The block watches the I/O address, the read and write strobes and the address-enable qualifier that marks DMA cycles. When an access falls inside the card's 16-port window, it raises the chip select of the one unit addressed. The two lowest address bits pass straight through as that unit's register select.

The window's base comes from six jumper links. A fitted link stands for a 0 and an open link for a 1, so the base is the bitwise inverse of the fitted pattern. The factory pattern places the card at 300h, and 200h is a common fallback. Each unit drives two interrupt lines. All eight are merged into one active-high host request, so any line a unit does not use must be held low.

Decode and merge are purely combinational: there is no clock and no state inside the block.

Top module: `pio_card_decoder`

## Requirements
- R1: Jumper input `jmp_fitted[k]` = 1 (link fitted) sets base address bit k+4 to 0, and 0 (link open) sets it to 1, for k = 0..5. Base bits 3:0 are always 0.
- R2: The card owns ports base..base+15. Unit n owns base+4n..base+4n+3. A qualified access there drives `unit_cs` = 1<<n, where n = address bits 3:2.
- R3: While a chip select is active, `reg_sel` equals address bits 1:0, where 3 selects the command register and 0..2 select data ports A, B and C.
- R4: With both `bus_rd_n` and `bus_wr_n` high, `unit_cs` is 0 for every address. A low read strobe or a low write strobe alone is enough to qualify an access.
- R5: With `bus_aen` high, `unit_cs` is 0 even for an address inside the window with a strobe active.
- R6: An address below base or above base+15 (for example base-1 or base+16) gives `unit_cs` = 0.
- R7: `host_irq` is high in the same evaluation whenever any single bit of `unit_irq` is high. Bit 2n is unit n's first line and bit 2n+1 its second.
- R8: `host_irq` is low when all eight `unit_irq` bits are low.
- R9: At most one bit of `unit_cs` is ever high.
- R10: The factory pattern `jmp_fitted` = 6'b001111 places the window at 300h–30Fh. The pattern 6'b011111 places it at 200h–20Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_addr | input | 10 | Host I/O address bits 9:0 |
| bus_rd_n | input | 1 | I/O read strobe, active low |
| bus_wr_n | input | 1 | I/O write strobe, active low |
| bus_aen | input | 1 | DMA address-enable qualifier, active high, blocks decode |
| jmp_fitted | input | 6 | Base jumpers, 1 = link fitted (base bit 0) |
| unit_irq | input | 8 | Interrupt lines, two per unit |
| unit_cs | output | 4 | One-hot unit chip selects, active high |
| reg_sel | output | 2 | Register select within the selected unit |
| host_irq | output | 1 | Merged interrupt request, active high |

## Verification
The immediate assertions assume the inputs are settled, two-state values whenever the combinational logic is evaluated. They also assume the jumper pattern is static for the duration of a bus access. The bench holds to both assumptions. It changes every input only on the falling clock edge, one full access at a time, and samples the outputs a nanosecond later. It changes the jumper pattern only between accesses, with both strobes idle.

// File: rtl/pio_dec_pkg.sv
package pio_dec_pkg;
  parameter int unsigned DEF_UNITS        = 4;
  parameter int unsigned DEF_REGS_PER_UNIT = 4;
  parameter int unsigned DEF_ADDR_W       = 10;
  parameter int unsigned DEF_IRQ_PER_UNIT = 2;
endpackage

// File: rtl/pio_base_match.sv
module pio_base_match #(
  parameter int unsigned HI_W = 6
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] jmp_fitted,
  output logic            hit
);
  logic [HI_W-1:0] bit_ok;

  // A fitted link means the base bit is 0, so each address bit must differ from its jumper.
  for (genvar k = 0; k < HI_W; k++) begin : g_bit
    assign bit_ok[k] = addr_hi[k] ^ jmp_fitted[k];
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/pio_unit_select.sv
module pio_unit_select #(
  parameter int unsigned UNITS  = 4,
  parameter int unsigned UNIT_W = 2
) (
  input  logic              en,
  input  logic [UNIT_W-1:0] unit_idx,
  output logic [UNITS-1:0]  cs
);
  for (genvar u = 0; u < UNITS; u++) begin : g_cs
    assign cs[u] = en && (unit_idx == UNIT_W'(u));
  end
endmodule

// File: rtl/pio_irq_merge.sv
module pio_irq_merge #(
  parameter int unsigned UNITS    = 4,
  parameter int unsigned PER_UNIT = 2
) (
  input  logic [UNITS*PER_UNIT-1:0] lines,
  output logic                      any
);
  logic [UNITS-1:0] unit_any;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign unit_any[u] = |lines[u*PER_UNIT +: PER_UNIT];
  end

  assign any = |unit_any;
endmodule

// File: rtl/pio_card_decoder.sv
module pio_card_decoder
  import pio_dec_pkg::*;
#(
  parameter int unsigned NUM_UNITS     = DEF_UNITS,
  parameter int unsigned REGS_PER_UNIT = DEF_REGS_PER_UNIT,
  parameter int unsigned ADDR_W        = DEF_ADDR_W,
  parameter int unsigned IRQ_PER_UNIT  = DEF_IRQ_PER_UNIT,
  localparam int unsigned SEL_W   = $clog2(REGS_PER_UNIT),
  localparam int unsigned UNIT_W  = $clog2(NUM_UNITS),
  localparam int unsigned WIN_LSB = SEL_W + UNIT_W,
  localparam int unsigned JMP_W   = ADDR_W - WIN_LSB,
  localparam int unsigned IRQ_W   = NUM_UNITS * IRQ_PER_UNIT
) (
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd_n,
  input  logic                 bus_wr_n,
  input  logic                 bus_aen,
  input  logic [JMP_W-1:0]     jmp_fitted,
  input  logic [IRQ_W-1:0]     unit_irq,
  output logic [NUM_UNITS-1:0] unit_cs,
  output logic [SEL_W-1:0]     reg_sel,
  output logic                 host_irq
);
  logic win_hit;
  logic strobe;
  logic decode_en;

  pio_base_match #(.HI_W(JMP_W)) u_match (
    .addr_hi   (bus_addr[ADDR_W-1:WIN_LSB]),
    .jmp_fitted(jmp_fitted),
    .hit       (win_hit)
  );

  assign strobe    = !bus_rd_n || !bus_wr_n;
  assign decode_en = win_hit && strobe && !bus_aen;

  pio_unit_select #(.UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_sel (
    .en      (decode_en),
    .unit_idx(bus_addr[WIN_LSB-1:SEL_W]),
    .cs      (unit_cs)
  );

  assign reg_sel = bus_addr[SEL_W-1:0];

  pio_irq_merge #(.UNITS(NUM_UNITS), .PER_UNIT(IRQ_PER_UNIT)) u_irq (
    .lines(unit_irq),
    .any  (host_irq)
  );
endmodule

// File: rtl/pio_card_decoder_chk.sv
module pio_card_decoder_chk #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned UNIT_W    = 2,
  parameter int unsigned JMP_W     = 6,
  parameter int unsigned IRQ_W     = 8
) (
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_rd_n,
  input logic                 bus_wr_n,
  input logic                 bus_aen,
  input logic [JMP_W-1:0]     jmp_fitted,
  input logic [IRQ_W-1:0]     unit_irq,
  input logic [NUM_UNITS-1:0] unit_cs,
  input logic [SEL_W-1:0]     reg_sel,
  input logic                 host_irq
);
  localparam int unsigned WIN_LSB = SEL_W + UNIT_W;

  always_comb begin
    a_r9_cs_onehot0: assert ($onehot0(unit_cs));
    if (unit_cs != '0) begin
      a_r4_cs_needs_strobe: assert (!bus_rd_n || !bus_wr_n);
      a_r5_cs_not_in_dma: assert (!bus_aen);
      a_r1_cs_inside_base: assert ((bus_addr[ADDR_W-1:WIN_LSB] & jmp_fitted) == '0
                                   && (bus_addr[ADDR_W-1:WIN_LSB] | jmp_fitted) == '1);
      a_r3_sel_passthrough: assert (reg_sel == bus_addr[SEL_W-1:0]);
    end
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_cs[u]) begin
        a_r2_unit_index: assert (int'(bus_addr[WIN_LSB-1:SEL_W]) == u);
      end
    end
    if ($countones(unit_irq) != 0) begin
      a_r7_irq_any: assert (host_irq);
    end
    if (host_irq) begin
      a_r8_irq_source: assert (unit_irq != '0);
    end
  end
endmodule

bind pio_card_decoder pio_card_decoder_chk #(
  .NUM_UNITS(NUM_UNITS),
  .ADDR_W   (ADDR_W),
  .SEL_W    (SEL_W),
  .UNIT_W   (UNIT_W),
  .JMP_W    (JMP_W),
  .IRQ_W    (IRQ_W)
) u_chk (
  .bus_addr  (bus_addr),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_aen   (bus_aen),
  .jmp_fitted(jmp_fitted),
  .unit_irq  (unit_irq),
  .unit_cs   (unit_cs),
  .reg_sel   (reg_sel),
  .host_irq  (host_irq)
);

// File: tb/pio_card_decoder_bench.sv
module pio_card_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] bus_addr = '0;
  logic       bus_rd_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic       bus_aen = 1'b0;
  logic [5:0] jmp_fitted = 6'b001111;
  logic [7:0] unit_irq = '0;
  logic [3:0] unit_cs;
  logic [1:0] reg_sel;
  logic       host_irq;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pio_card_decoder u_pio_card_decoder (
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_aen(bus_aen), .jmp_fitted(jmp_fitted), .unit_irq(unit_irq),
    .unit_cs(unit_cs), .reg_sel(reg_sel), .host_irq(host_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int base_of(input logic [5:0] jf);
    return int'({~jf, 4'b0000});
  endfunction

  function automatic int exp_cs(input int a, input logic rd_n, input logic wr_n,
                                input logic aen, input logic [5:0] jf);
    int b = base_of(jf);
    if (!aen && (!rd_n || !wr_n) && a >= b && a < b + 16) return 1 << ((a - b) / 4);
    return 0;
  endfunction

  task automatic access(input int a, input logic rd_n, input logic wr_n, input logic aen);
    @(negedge clk);
    bus_addr = 10'(a); bus_rd_n = rd_n; bus_wr_n = wr_n; bus_aen = aen;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_aen = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R4 idle cs", int'(unit_cs), 0);
    chk("R8 idle irq", int'(host_irq), 0);
  endtask

  task automatic t_window(input logic [5:0] jf, input int base, input string req);
    idle(); jmp_fitted = jf;
    for (int off = 0; off < 16; off++) begin
      access(base + off, off[0], !off[0], 1'b0);
      chk({req, " R2 cs"}, int'(unit_cs), 1 << (off / 4));
      chk({req, " R3 sel"}, int'(reg_sel), off % 4);
      chk("R9 model", int'(unit_cs), exp_cs(base + off, off[0], !off[0], 1'b0, jf));
    end
    idle();
  endtask

  task automatic t_jumper_walk();
    for (int k = 0; k < 6; k++) begin
      logic [5:0] jf = 6'(1 << k);
      idle(); jmp_fitted = jf;
      access(base_of(jf) + 9, 1'b0, 1'b1, 1'b0);
      chk("R1 walk cs", int'(unit_cs), 4'b0100);
      chk("R3 walk sel", int'(reg_sel), 1);
      access(base_of(jf) ^ (16 << k), 1'b0, 1'b1, 1'b0);
      chk("R1 flipped bit", int'(unit_cs), 0);
    end
    idle(); jmp_fitted = 6'b001111;
  endtask

  task automatic t_outside();
    idle(); jmp_fitted = 6'b001111;
    access(10'h2FF, 1'b0, 1'b1, 1'b0); chk("R6 below", int'(unit_cs), 0);
    access(10'h310, 1'b0, 1'b1, 1'b0); chk("R6 above", int'(unit_cs), 0);
    access(10'h203, 1'b1, 1'b0, 1'b0); chk("R6 other base", int'(unit_cs), 0);
    idle();
  endtask

  task automatic t_no_strobe();
    idle(); jmp_fitted = 6'b001111;
    for (int off = 0; off < 16; off += 5) begin
      access(10'h300 + off, 1'b1, 1'b1, 1'b0);
      chk("R4 no strobe", int'(unit_cs), 0);
    end
    access(10'h30B, 1'b0, 1'b0, 1'b0);
    chk("R4 both strobes", int'(unit_cs), 4'b0100);
    idle();
  endtask

  task automatic t_aen();
    idle(); jmp_fitted = 6'b001111;
    access(10'h307, 1'b0, 1'b1, 1'b1); chk("R5 aen read", int'(unit_cs), 0);
    access(10'h30F, 1'b1, 1'b0, 1'b1); chk("R5 aen write", int'(unit_cs), 0);
    access(10'h30F, 1'b1, 1'b0, 1'b0); chk("R5 aen released", int'(unit_cs), 4'b1000);
    idle();
  endtask

  task automatic t_irq();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); unit_irq = 8'(1 << i); #1;
      chk("R7 single line", int'(host_irq), 1);
    end
    @(negedge clk); unit_irq = 8'h09; #1; chk("R7 two lines", int'(host_irq), 1);
    @(negedge clk); unit_irq = 8'h00; #1; chk("R8 all low", int'(host_irq), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset_state();
    t_window(6'b001111, 10'h300, "R10 300h");
    t_window(6'b011111, 10'h200, "R10 200h");
    t_jumper_walk();
    t_outside();
    t_no_strobe();
    t_aen();
    t_irq();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule